// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block holds the almost-empty and almost-full threshold values that a FIFO's flag comparators use. Both values are loaded over the FIFO's own parallel data bus in a short run of write cycles and can be read back over the output bus in a matching run of read cycles. An internal cycle sequencer keeps track of which register is targeted next and which slice of it. The almost-empty register always comes first, then the almost-full register. After the last slice of the almost-full register the sequencer wraps back to the start.

Each side of the bus is either 9 or 18 bits wide, chosen by a static mode pin. An 18-bit side can also use a layout with interspersed parity, where bus bit 8 carries no offset data. The offset width comes from the parameter `DEPTH_BITS`. It is one bit wider when both sides are 9 bits wide. The slice count for each register is the offset width divided by the usable lane width, rounded up. Read-back accesses must be spaced apart: a read enable held high on two consecutive clocks is flagged, and the second access is dropped.

Top module: `flag_ofs_loader`

## Requirements
- R1: While reset is asserted and afterwards until the first write, `emptyOfs` and `fullOfs` equal `DEF_OFS` (default 127), and `rdValid` and `rdViol` are 0. The write and read sequencers both point at slice 0 of the almost-empty register.
- R2: Each sequencer walks through every slice of the almost-empty register, then every slice of the almost-full register, and then wraps back to almost-empty slice 0. Writes to one register leave the other register's value unchanged.
- R3: The lane width is 18 bits on an 18-bit side, 17 bits on an 18-bit side with interspersed parity, and 9 bits on a 9-bit side. A register takes ceil(width/lane) cycles. With the defaults this gives 1, 2, 2 and 3 cycles for wide, wide with parity, mixed 9-bit and 9-to-9 sides respectively.
- R4: The offset width is `DEPTH_BITS` (18 by default) when either side is 18 bits, and `DEPTH_BITS`+1 when both sides are 9 bits. `emptyOfs` and `fullOfs` show 0 at and above the current offset width.
- R5: Slice k carries offset bits k*lane up to k*lane+lane-1. Lane bit j sits on bus bit j. In the parity layout, lane bits 8 and above move up one position, so bus bit 8 is skipped.
- R6: On a write, bus bits that lie outside the lane, at or above the offset width, or on bit 8 in the parity layout have no effect on any stored offset.
- R7: An accepted read puts the targeted slice on `rdData`, with `rdValid` high, one clock after the `rdEn` edge. Bus bits that carry no offset bit read as 0.
- R8: If `rdEn` is high on a clock and was also high on the previous clock, then on the next cycle `rdViol` is 1 and `rdValid` is 0. The read pointer does not advance.
- R9: The write pointer and the read pointer advance independently, each using its own side's width. With a 9-bit input and an 18-bit output, a load takes 4 writes and a read-back takes 2 reads. The reverse arrangement takes 2 writes and 4 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write and read sides |
| rstN | input | 1 | Asynchronous active-low reset |
| wideIn | input | 1 | Input bus is 18 bits wide (else 9) |
| wideOut | input | 1 | Output bus is 18 bits wide (else 9) |
| parityIl | input | 1 | An 18-bit side uses the interspersed-parity layout |
| wrEn | input | 1 | Load one slice from `wrData` |
| wrData | input | 18 | Input data bus |
| rdEn | input | 1 | Request one read-back slice |
| rdData | output | 18 | Read-back slice |
| rdValid | output | 1 | `rdData` holds a fresh slice |
| rdViol | output | 1 | Back-to-back read request was dropped |
| emptyOfs | output | DEPTH_BITS+1 | Almost-empty offset to the flag logic |
| fullOfs | output | DEPTH_BITS+1 | Almost-full offset to the flag logic |

## Verification
A write changes `emptyOfs` or `fullOfs` at the clock edge that samples `wrEn`. The bench checks the offsets at the falling edge after that clock. An accepted read sets `rdValid` and `rdData` at the same edge. The scoreboard monitor therefore pops the expected slice at the falling edge following the `rdEn` clock, and reports any `rdValid` it did not expect. A violation shows up on `rdViol` one falling edge after the second high `rdEn`. The following read is then checked to return the slice that was skipped, which shows the pointer did not move.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

  localparam int SLC_W = 3;
  localparam int BUS_W = 18;

  typedef struct packed {
    logic             wrGo;
    logic             wrFull;
    logic [SLC_W-1:0] wrSlc;
    logic             rdGo;
    logic             rdViol;
    logic             rdFull;
    logic [SLC_W-1:0] rdSlc;
  } ofsStrb_t;

  function automatic int laneBits(logic wide, logic par);
    if (!wide) return 9;
    return par ? 17 : 18;
  endfunction

endpackage

// File: rtl/flag_ofs_ctrl.sv
module flag_ofs_ctrl
  import flag_ofs_pkg::*;
#(
  parameter int DEPTH_BITS = 18
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wideIn,
  input  logic     wideOut,
  input  logic     parityIl,
  input  logic     wrEn,
  input  logic     rdEn,
  output ofsStrb_t strb
);

  localparam int W0     = DEPTH_BITS;
  localparam int W1     = DEPTH_BITS + 1;
  localparam int N_WIDE = (W0 + 17) / 18;
  localparam int N_PAR  = (W0 + 16) / 17;
  localparam int N_MIX  = (W0 + 8) / 9;
  localparam int N_NAR  = (W1 + 8) / 9;

  function automatic logic [SLC_W-1:0] lastSlice(logic ownWide, logic otherWide, logic par);
    int n;
    if (ownWide) n = par ? N_PAR : N_WIDE;
    else         n = otherWide ? N_MIX : N_NAR;
    return SLC_W'(n - 1);
  endfunction

  logic             wrFull, rdFull, prevRd;
  logic [SLC_W-1:0] wrSlc, rdSlc;
  logic [SLC_W-1:0] wrLast, rdLast;
  logic             rdGo;

  assign wrLast = lastSlice(wideIn, wideOut, parityIl);
  assign rdLast = lastSlice(wideOut, wideIn, parityIl);
  assign rdGo   = rdEn && !prevRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrFull <= 1'b0;
      wrSlc  <= '0;
    end else if (wrEn) begin
      if (wrSlc >= wrLast) begin
        wrSlc  <= '0;
        wrFull <= ~wrFull;
      end else begin
        wrSlc <= wrSlc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdFull <= 1'b0;
      rdSlc  <= '0;
      prevRd <= 1'b0;
    end else begin
      prevRd <= rdEn;
      if (rdGo) begin
        if (rdSlc >= rdLast) begin
          rdSlc  <= '0;
          rdFull <= ~rdFull;
        end else begin
          rdSlc <= rdSlc + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.wrGo   = wrEn;
    strb.wrFull = wrFull;
    strb.wrSlc  = wrSlc;
    strb.rdGo   = rdGo;
    strb.rdViol = rdEn && prevRd;
    strb.rdFull = rdFull;
    strb.rdSlc  = rdSlc;
  end

endmodule

// File: rtl/flag_ofs_dpath.sv
module flag_ofs_dpath
  import flag_ofs_pkg::*;
#(
  parameter int                  DEPTH_BITS = 18,
  parameter logic [DEPTH_BITS:0] DEF_OFS    = 127
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wideIn,
  input  logic                  wideOut,
  input  logic                  parityIl,
  input  logic [BUS_W-1:0]      wrData,
  input  ofsStrb_t              strb,
  output logic [BUS_W-1:0]      rdData,
  output logic                  rdValid,
  output logic                  rdViol,
  output logic [DEPTH_BITS:0]   emptyOfs,
  output logic [DEPTH_BITS:0]   fullOfs
);

  localparam int MAXW = DEPTH_BITS + 1;
  localparam int IW   = $clog2(MAXW);

  logic          bothNarrow, wrPar, rdPar;
  int            effW, wrLane, rdLane, wrBase, rdBase;
  logic [MAXW-1:0] emptyQ, fullQ, wHit, wBit, rdSrc, outMask;
  logic [BUS_W-1:0] rBit;

  assign bothNarrow = !wideIn && !wideOut;
  assign effW    = bothNarrow ? MAXW : MAXW - 1;
  assign wrPar   = wideIn && parityIl;
  assign rdPar   = wideOut && parityIl;
  assign wrLane  = laneBits(wideIn, parityIl);
  assign rdLane  = laneBits(wideOut, parityIl);
  assign wrBase  = int'(strb.wrSlc) * wrLane;
  assign rdBase  = int'(strb.rdSlc) * rdLane;
  assign outMask = {bothNarrow, {(MAXW-1){1'b1}}};
  assign rdSrc   = strb.rdFull ? fullQ : emptyQ;

  function automatic logic inLane(int idx, int base, int lane, int w);
    int rel;
    rel = idx - base;
    return (rel >= 0) && (rel < lane) && (idx < w);
  endfunction

  function automatic logic [4:0] busPos(int rel, logic par);
    int b;
    b = (par && rel >= 8) ? rel + 1 : rel;
    if (b < 0 || b >= BUS_W) b = 0;
    return 5'(b);
  endfunction

  function automatic int srcIdx(int b, logic wide, logic par, int base, int w);
    int rel;
    if (!wide && b >= 9) return -1;
    if (par && b == 8) return -1;
    rel = (par && b > 8) ? b - 1 : b;
    if (base + rel >= w) return -1;
    return base + rel;
  endfunction

  for (genvar i = 0; i < MAXW; i++) begin : g_wrBit
    assign wHit[i] = strb.wrGo && inLane(i, wrBase, wrLane, effW);
    assign wBit[i] = wrData[busPos(i - wrBase, wrPar)];
  end

  for (genvar b = 0; b < BUS_W; b++) begin : g_rdBit
    int idx;
    assign idx     = srcIdx(b, wideOut, rdPar, rdBase, effW);
    assign rBit[b] = (idx >= 0) ? rdSrc[idx[IW-1:0]] : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyQ <= DEF_OFS;
      fullQ  <= DEF_OFS;
    end else if (strb.wrFull) begin
      fullQ  <= (fullQ & ~wHit) | (wBit & wHit);
    end else begin
      emptyQ <= (emptyQ & ~wHit) | (wBit & wHit);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      rdViol  <= 1'b0;
    end else begin
      rdValid <= strb.rdGo;
      rdViol  <= strb.rdViol;
      if (strb.rdGo) rdData <= rBit;
    end
  end

  assign emptyOfs = emptyQ & outMask;
  assign fullOfs  = fullQ & outMask;

endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
  import flag_ofs_pkg::*;
#(
  parameter int                  DEPTH_BITS = 18,
  parameter logic [DEPTH_BITS:0] DEF_OFS    = 127
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wideIn,
  input  logic                wideOut,
  input  logic                parityIl,
  input  logic                wrEn,
  input  logic [17:0]         wrData,
  input  logic                rdEn,
  output logic [17:0]         rdData,
  output logic                rdValid,
  output logic                rdViol,
  output logic [DEPTH_BITS:0] emptyOfs,
  output logic [DEPTH_BITS:0] fullOfs
);

  ofsStrb_t strb;

  flag_ofs_ctrl #(.DEPTH_BITS(DEPTH_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .wideIn(wideIn), .wideOut(wideOut),
    .parityIl(parityIl), .wrEn(wrEn), .rdEn(rdEn), .strb(strb)
  );

  flag_ofs_dpath #(.DEPTH_BITS(DEPTH_BITS), .DEF_OFS(DEF_OFS)) dpath_i (
    .clk(clk), .rstN(rstN), .wideIn(wideIn), .wideOut(wideOut),
    .parityIl(parityIl), .wrData(wrData), .strb(strb),
    .rdData(rdData), .rdValid(rdValid), .rdViol(rdViol),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs)
  );

endmodule

// File: rtl/flag_ofs_loader_chk.sv
module flag_ofs_loader_chk #(
  parameter int DEPTH_BITS = 18
) (
  input logic                clk,
  input logic                rstN,
  input logic                wideIn,
  input logic                wideOut,
  input logic                wrEn,
  input logic                rdEn,
  input logic [17:0]         rdData,
  input logic                rdValid,
  input logic                rdViol,
  input logic [DEPTH_BITS:0] emptyOfs,
  input logic [DEPTH_BITS:0] fullOfs
);

  // R8: a dropped access never also reports data
  a_r8_viol_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && rdViol));

  // R8: an accepted read is never followed by another accepted read
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R8: a violation needs a request on the clock before
  a_r8_viol_cause: assert property (@(posedge clk) disable iff (!rstN)
    rdViol |-> $past(rdEn));

  // R7: read data only follows a request
  a_r7_valid_cause: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn));

  // R7: upper bus half reads zero on a 9-bit output
  a_r7_narrow_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !$past(wideOut)) |-> (rdData[17:9] == 9'd0));

  // R2: offsets hold without a write unless the width mode moved
  a_r2_hold_empty: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(emptyOfs) || !$stable({wideIn, wideOut})));

  a_r2_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(fullOfs) || !$stable({wideIn, wideOut})));

endmodule

bind flag_ofs_loader flag_ofs_loader_chk #(.DEPTH_BITS(DEPTH_BITS)) chk_i (
  .clk(clk), .rstN(rstN), .wideIn(wideIn), .wideOut(wideOut),
  .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
  .rdViol(rdViol), .emptyOfs(emptyOfs), .fullOfs(fullOfs)
);

// File: tb/flag_ofs_loader_tb_top.sv
module flag_ofs_loader_tb_top;

  localparam int DB = 18;
  localparam int MW = DB + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wideIn = 1'b1, wideOut = 1'b1, parityIl = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [17:0]   wrData = '0;
  logic [17:0]   rdData;
  logic          rdValid, rdViol;
  logic [MW-1:0] emptyOfs, fullOfs;

  int errors = 0;
  int checks = 0;
  logic [17:0] expQ[$];
  logic [MW-1:0] mE = 127, mF = 127;

  always #10 clk = ~clk;

  flag_ofs_loader #(.DEPTH_BITS(DB), .DEF_OFS(127)) dut_i (
    .clk(clk), .rstN(rstN), .wideIn(wideIn), .wideOut(wideOut),
    .parityIl(parityIl), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .rdValid(rdValid), .rdViol(rdViol),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int laneOf(logic wide, logic par);
    return !wide ? 9 : (par ? 17 : 18);
  endfunction

  function automatic logic [MW-1:0] maskOf(int w);
    return (w == MW) ? {MW{1'b1}} : {1'b0, {(MW-1){1'b1}}};
  endfunction

  // R5 placement; fill=1 sets every bus bit that carries no offset bit (R6)
  function automatic logic [17:0] busWord(logic [MW-1:0] v, int k, logic wide,
                                          logic par, int w, logic fill);
    logic [17:0] word;
    int lane;
    lane = laneOf(wide, par);
    word = fill ? '1 : '0;
    for (int j = 0; j < lane; j++) begin
      int bi;
      int b;
      bi = k * lane + j;
      b  = (wide && par && j >= 8) ? j + 1 : j;
      if (bi < w) word[b] = v[bi];
    end
    return word;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check("R7 unexpected rdValid", 1, 0);
      end else begin
        logic [17:0] e;
        e = expQ.pop_front();
        check("R5/R7 read slice", 32'(rdData), 32'(e));
      end
    end
  end

  task automatic writeReg(logic [MW-1:0] v, int n, int w);
    for (int k = 0; k < n; k++) begin
      wrData = busWord(v, k, wideIn, parityIl, w, 1'b1);
      wrEn   = 1'b1;
      @(negedge clk);
    end
    wrEn   = 1'b0;
    wrData = '1;
  endtask

  task automatic readOne(logic [17:0] e);
    expQ.push_back(e);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic runMode(logic wi, logic wo, logic par, logic [MW-1:0] vE,
                         logic [MW-1:0] vF, logic violTest);
    int w, nW, nR;
    logic [MW-1:0] msk;
    wideIn = wi; wideOut = wo; parityIl = par;
    @(negedge clk);
    w   = (!wi && !wo) ? MW : MW - 1;
    msk = maskOf(w);
    nW  = (w + laneOf(wi, par) - 1) / laneOf(wi, par);
    nR  = (w + laneOf(wo, par) - 1) / laneOf(wo, par);
    check("R4 empty mask on mode change", 32'(emptyOfs), 32'(mE & msk));
    // R3/R9: exactly nW writes finish the almost-empty register, full untouched
    writeReg(vE, nW, w);
    mE = (mE & ~msk) | (vE & msk);
    check("R3 empty after its slices", 32'(emptyOfs), 32'(mE & msk));
    check("R2 full untouched by empty load", 32'(fullOfs), 32'(mF & msk));
    writeReg(vF, nW, w);
    mF = (mF & ~msk) | (vF & msk);
    check("R2 full loaded second", 32'(fullOfs), 32'(mF & msk));
    check("R2 empty untouched by full load", 32'(emptyOfs), 32'(mE & msk));
    // two rounds of read-back; second round proves the wrap (R2, R9)
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < nR; k++)
        readOne(busWord(mE, k, wo, par, w, 1'b0));
      if (violTest && r == 0) begin
        // R8: back-to-back request on full slice 0
        expQ.push_back(busWord(mF, 0, wo, par, w, 1'b0));
        rdEn = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 rdViol flagged", 32'(rdViol), 1);
        check("R8 rdValid dropped", 32'(rdValid), 0);
        rdEn = 1'b0;
        @(negedge clk);
        check("R8 rdViol clears", 32'(rdViol), 0);
        for (int k = 1; k < nR; k++)
          readOne(busWord(mF, k, wo, par, w, 1'b0));
      end else begin
        for (int k = 0; k < nR; k++)
          readOne(busWord(mF, k, wo, par, w, 1'b0));
      end
    end
    check("R7 scoreboard drained", 32'(expQ.size()), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 empty reset", 32'(emptyOfs), 127);
    check("R1 full reset", 32'(fullOfs), 127);
    check("R1 rdValid reset", 32'(rdValid), 0);
    check("R1 rdViol reset", 32'(rdViol), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 empty after reset", 32'(emptyOfs), 127);
    // R1: first read targets almost-empty slice 0
    readOne(busWord(mE, 0, 1'b1, 1'b0, MW - 1, 1'b0));
    readOne(busWord(mF, 0, 1'b1, 1'b0, MW - 1, 1'b0));
    // R4: 9-to-9 uses the extra top bit
    runMode(1'b0, 1'b0, 1'b0, 19'h5A5A5 | 19'h40000, 19'h6C3B1, 1'b0);
    check("R4 top bit held in 9-to-9", 32'(emptyOfs[MW-1]), 1);
    runMode(1'b1, 1'b1, 1'b0, 19'h2F00D, 19'h15555, 1'b1);
    check("R4 top bit masked with a wide side", 32'(emptyOfs[MW-1]), 0);
    runMode(1'b1, 1'b1, 1'b1, 19'h3FEFF, 19'h00100, 1'b1);
    runMode(1'b0, 1'b1, 1'b0, 19'h12345, 19'h2ABCD, 1'b0);
    runMode(1'b1, 1'b0, 1'b0, 19'h0F0F0, 19'h30303, 1'b1);
    runMode(1'b0, 1'b1, 1'b1, 19'h3FFFF, 19'h00001, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule